// File: doc/BRIEF.md
# LCD Row-Scan Timing Generator

This block produces the row-scan timing for a multiplexed dot-matrix LCD. A slow line clock comes in on `line_clk`, and every transition of it counts: a rising edge and a falling edge each advance the scan position by one line. From the scan position the block forms three things. The first is the display RAM line to fetch, which is the scan position plus a programmable start line, modulo 32. The second is a one-hot select for the chip's 16 common drivers. The third is a frame-polarity signal that the segment and common drivers use for AC inversion. Each advance also produces a one-cycle strobe that tells the segment latch to capture the fetched line.

The frame is either 16 or 32 lines long. A 32-line frame is shared by two chips. The primary chip drives its commons for scan lines 0–15, and the secondary chip drives its commons for lines 16–31. The primary chip owns the frame-polarity signal and inverts it each time its scan position wraps to zero. The secondary chip receives that signal on `fr_in`, passes it on, and treats each of its edges as the start of line 0, which keeps the two chips in step. When the display is blanked, every common select is held low but scanning continues.

The block runs on a fast system clock `clk`. `line_clk` and `fr_in` are treated as synchronous levels sampled on that clock.

Top module: `lcd_scan_timing`

## Requirements
- R1: After reset the scan position is 0, the frame polarity is 0 and the strobe is low. With the display on, in primary mode, `com_sel` is 1 (bit 0) and `ram_line` equals `start_line`.
- R2: Every change of `line_clk`, rising or falling, advances the scan position by one. In the clock cycle after the edge is sampled, `latch_stb` is high for exactly one cycle.
- R3: `ram_line` is always (scan position + `start_line`) mod 32.
- R4: With `duty_full`=0 the scan position wraps from 15 to 0. In primary mode, `fr_out` inverts at that wrap.
- R5: With `duty_full`=1 the scan position wraps from 31 to 0. In primary mode, `fr_out` inverts at that wrap and at no other scan position.
- R6: With `duty_full`=1 the primary chip (`is_slave`=0) drives `com_sel` bit (position mod 16) only for positions 0–15, and the secondary chip does so only for positions 16–31. With `duty_full`=0 both drive bit (position) on every line. At most one bit of `com_sel` is ever high.
- R7: While `disp_on`=0, `com_sel` is all zero and the scan position keeps advancing.
- R8: In secondary mode `fr_out` equals `fr_in` delayed by one clock, and the chip never inverts the polarity on its own.
- R9: In secondary mode an edge of `fr_in` sets the scan position to 0. If a `line_clk` change is sampled in the same cycle, the position becomes 1 instead.
- R10: Without a `line_clk` change (and, in secondary mode, without an `fr_in` edge), the scan position is held and `latch_stb` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_clk | input | 1 | Line clock level; each change advances one line |
| duty_full | input | 1 | 0: 16-line frame, 1: 32-line frame |
| start_line | input | 5 | RAM line shown at scan position 0 |
| is_slave | input | 1 | 0: primary chip, 1: secondary chip |
| disp_on | input | 1 | 0 blanks all common selects |
| fr_in | input | 1 | Frame polarity from the primary chip (secondary mode) |
| ram_line | output | 5 | Display RAM line to fetch |
| com_sel | output | 16 | One-hot common driver select |
| fr_out | output | 1 | Frame polarity |
| latch_stb | output | 1 | One-cycle line-latch strobe |

## Verification
In a secondary chip, a polarity edge from the primary and a line-clock change can be sampled in the same system clock cycle. The resync then competes with the normal advance. The bench provokes this by driving both inputs on the same falling clock edge. It judges the result by the fetched RAM line one cycle later, which must show position 1, not 0 or the old position plus one. Frame wrap and polarity inversion coincide by design, so the bench also checks them together at each wrap.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
    parameter int unsigned SCAN_LINE_W = 5;

    typedef struct packed {
        logic                   cl;
        logic                   fr_in;
        logic                   fr;
        logic                   stb;
        logic [SCAN_LINE_W-1:0] line;
    } scan_state_t;
endpackage

// File: rtl/lcd_line_seq.sv
module lcd_line_seq
    import lcd_scan_pkg::*;
#(
    parameter int unsigned LINE_W = SCAN_LINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_clk,
    input  logic              duty_full,
    input  logic              is_slave,
    input  logic              fr_in,
    output logic [LINE_W-1:0] line_q,
    output logic              fr_q,
    output logic              fr_in_q,
    output logic              stb_q
);
    localparam int unsigned LINES     = 2 ** LINE_W;
    localparam logic [LINE_W-1:0] LAST_FULL = LINE_W'(LINES - 1);
    localparam logic [LINE_W-1:0] LAST_HALF = LINE_W'(LINES / 2 - 1);

    scan_state_t st_d, st_q;
    logic              step;
    logic              fr_edge;
    logic              at_end;
    logic [LINE_W-1:0] base;
    logic [LINE_W-1:0] last;

    always_comb begin
        st_d     = st_q;
        step     = (line_clk != st_q.cl);
        fr_edge  = is_slave && (fr_in != st_q.fr_in);
        last     = duty_full ? LAST_FULL : LAST_HALF;
        base     = fr_edge ? '0 : st_q.line;
        at_end   = (base >= last);
        st_d.cl    = line_clk;
        st_d.fr_in = fr_in;
        st_d.stb   = step;
        if (step) begin
            st_d.line = at_end ? '0 : base + 1'b1;
        end else begin
            st_d.line = base;
        end
        if (step && at_end && !is_slave) begin
            st_d.fr = ~st_q.fr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_q  = st_q.line;
    assign fr_q    = st_q.fr;
    assign fr_in_q = st_q.fr_in;
    assign stb_q   = st_q.stb;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !fr_edge) |=> $stable(line_q)); // R10

    AST_FR_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_slave && $past(!is_slave) && (fr_q != $past(fr_q))) |-> (line_q == '0)); // R5
endmodule

// File: rtl/lcd_row_map.sv
module lcd_row_map #(
    parameter int unsigned LINE_W = 5
) (
    input  logic [LINE_W-1:0] scan_line,
    input  logic [LINE_W-1:0] start_line,
    output logic [LINE_W-1:0] ram_line
);
    always_comb begin
        ram_line = scan_line + start_line;
    end
endmodule

// File: rtl/lcd_com_decode.sv
module lcd_com_decode #(
    parameter int unsigned LINE_W = 5
) (
    input  logic [LINE_W-1:0]          scan_line,
    input  logic                       duty_full,
    input  logic                       is_slave,
    input  logic                       disp_on,
    output logic [2**(LINE_W-1)-1:0]   com_sel
);
    localparam int unsigned COMS  = 2 ** (LINE_W - 1);
    localparam int unsigned COM_W = LINE_W - 1;

    logic chip_active;

    always_comb begin
        chip_active = disp_on && (!duty_full || (scan_line[LINE_W-1] == is_slave));
    end

    for (genvar i = 0; i < COMS; i++) begin : g_com
        assign com_sel[i] = chip_active && (scan_line[COM_W-1:0] == COM_W'(i));
    end
endmodule

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing
    import lcd_scan_pkg::*;
#(
    parameter int unsigned LINE_W = SCAN_LINE_W,
    parameter int unsigned COMS   = 2 ** (LINE_W - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_clk,
    input  logic              duty_full,
    input  logic [LINE_W-1:0] start_line,
    input  logic              is_slave,
    input  logic              disp_on,
    input  logic              fr_in,
    output logic [LINE_W-1:0] ram_line,
    output logic [COMS-1:0]   com_sel,
    output logic              fr_out,
    output logic              latch_stb
);
    logic [LINE_W-1:0] line_q;
    logic              fr_q;
    logic              fr_in_q;

    lcd_line_seq #(.LINE_W(LINE_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_clk  (line_clk),
        .duty_full (duty_full),
        .is_slave  (is_slave),
        .fr_in     (fr_in),
        .line_q    (line_q),
        .fr_q      (fr_q),
        .fr_in_q   (fr_in_q),
        .stb_q     (latch_stb)
    );

    lcd_row_map #(.LINE_W(LINE_W)) u_map (
        .scan_line  (line_q),
        .start_line (start_line),
        .ram_line   (ram_line)
    );

    lcd_com_decode #(.LINE_W(LINE_W)) u_com (
        .scan_line (line_q),
        .duty_full (duty_full),
        .is_slave  (is_slave),
        .disp_on   (disp_on),
        .com_sel   (com_sel)
    );

    assign fr_out = is_slave ? fr_in_q : fr_q;

    AST_COM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(com_sel)); // R6

    AST_ROW_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (LINE_W'(ram_line - start_line) == line_q)); // R3

    AST_SLAVE_FR: assert property (@(posedge clk) disable iff (!rst_n)
        (is_slave && $past(is_slave)) |-> (fr_out == $past(fr_in))); // R8
endmodule

// File: tb/lcd_scan_timing_tb.sv
`timescale 1ns/1ps
module lcd_scan_timing_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_clk = 1'b0;
    logic        duty_full = 1'b0;
    logic [4:0]  start_line = '0;
    logic        is_slave = 1'b0;
    logic        disp_on = 1'b1;
    logic        fr_in = 1'b0;
    logic [4:0]  ram_line;
    logic [15:0] com_sel;
    logic        fr_out;
    logic        latch_stb;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lcd_scan_timing dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_clk   (line_clk),
        .duty_full  (duty_full),
        .start_line (start_line),
        .is_slave   (is_slave),
        .disp_on    (disp_on),
        .fr_in      (fr_in),
        .ram_line   (ram_line),
        .com_sel    (com_sel),
        .fr_out     (fr_out),
        .latch_stb  (latch_stb)
    );

    typedef struct packed {
        logic        duty;
        logic [4:0]  start;
        logic [5:0]  edges;
        logic [4:0]  exp_ram;
        logic        exp_fr;
        logic [15:0] exp_com;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 5'd0,  6'd5,  5'd5,  1'b0, 16'h0020},
        '{1'b0, 5'd3,  6'd10, 5'd18, 1'b0, 16'h8000},
        '{1'b0, 5'd3,  6'd1,  5'd3,  1'b1, 16'h0001},
        '{1'b0, 5'd31, 6'd2,  5'd1,  1'b1, 16'h0004},
        '{1'b1, 5'd0,  6'd14, 5'd16, 1'b1, 16'h0000},
        '{1'b1, 5'd20, 6'd15, 5'd19, 1'b1, 16'h0000},
        '{1'b1, 5'd20, 6'd1,  5'd20, 1'b0, 16'h0001},
        '{1'b1, 5'd0,  6'd17, 5'd17, 1'b0, 16'h0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        line_clk = 1'b0;
        fr_in = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_edges(input int n);
        for (int k = 0; k < n; k++) begin
            line_clk = ~line_clk;
            @(negedge clk);
        end
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        start_line = 5'd7;
        do_reset();
        chk("R1 ram_line", 32'(ram_line), 32'd7);
        chk("R1 fr_out", 32'(fr_out), 32'd0);
        chk("R1 latch_stb", 32'(latch_stb), 32'd0);
        chk("R1 com_sel", 32'(com_sel), 32'h1);

        // table walk (R3 R4 R5 R6), primary mode
        start_line = 5'd0;
        do_reset();
        for (int v = 0; v < NV; v++) begin
            duty_full  = VEC[v].duty;
            start_line = VEC[v].start;
            do_edges(int'(VEC[v].edges));
            chk("R3 ram_line", 32'(ram_line), 32'(VEC[v].exp_ram));
            chk("R4/R5 fr_out", 32'(fr_out), 32'(VEC[v].exp_fr));
            chk("R6 com_sel", 32'(com_sel), 32'(VEC[v].exp_com));
        end

        // R2 both edges advance, one-cycle strobe; R10 hold when idle
        duty_full = 1'b0;
        start_line = 5'd0;
        do_reset();
        line_clk = 1'b1;
        @(negedge clk);
        chk("R2 rise advance", 32'(ram_line), 32'd1);
        chk("R2 strobe high", 32'(latch_stb), 32'd1);
        @(negedge clk);
        chk("R2 strobe one cycle", 32'(latch_stb), 32'd0);
        line_clk = 1'b0;
        @(negedge clk);
        chk("R2 fall advance", 32'(ram_line), 32'd2);
        repeat (5) @(negedge clk);
        chk("R10 hold line", 32'(ram_line), 32'd2);
        chk("R10 no strobe", 32'(latch_stb), 32'd0);

        // R7 blanking keeps scan running
        do_reset();
        disp_on = 1'b0;
        do_edges(3);
        chk("R7 blank com", 32'(com_sel), 32'h0);
        chk("R7 scan runs", 32'(ram_line), 32'd3);
        disp_on = 1'b1;
        #1;
        chk("R7 com after unblank", 32'(com_sel), 32'h8);

        // secondary chip: R6 R8 R9
        is_slave = 1'b1;
        duty_full = 1'b1;
        do_reset();
        chk("R6 slave idle at line0", 32'(com_sel), 32'h0);
        do_edges(16);
        chk("R6 slave line16", 32'(com_sel), 32'h1);
        do_edges(3);
        chk("R6 slave line19", 32'(com_sel), 32'h8);
        chk("R8 slave no own toggle", 32'(fr_out), 32'd0);
        fr_in = 1'b1;
        @(negedge clk);
        chk("R9 resync to 0", 32'(ram_line), 32'd0);
        chk("R8 fr follows", 32'(fr_out), 32'd1);
        fr_in = 1'b0;
        line_clk = ~line_clk;
        @(negedge clk);
        chk("R9 resync with step", 32'(ram_line), 32'd1);
        chk("R8 fr follows low", 32'(fr_out), 32'd0);
        chk("R2 strobe on coincide", 32'(latch_stb), 32'd1);

        is_slave = 1'b0;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule